// File: doc/BRIEF.md
# Two-Channel PCM Audio Serial Port (Master)

This block is the master side of a synchronous serial link to a PCM voice codec. From the system clock it makes a bit clock and a frame-sync pulse. In every frame it moves one word per channel out on a data-out line and captures one word per channel from a data-in line. There are two channels. Each channel has its own start position, counted in bit clocks from frame sync, and its own word length. The start position, the length and the bit order are set separately for the transmit direction and the receive direction.

The master can stop the bit clock for a programmed window inside each frame, so a frame can carry fewer clock pulses than its nominal length. Data-out has an output enable that is low between words and can be held low at all times. If a setting is illegal, an error flag goes high and the port stays silent until the setting is corrected. Transmit words are taken from the parallel inputs at the start of each frame. Received words are presented, with a one-cycle strobe, at the start of the following frame.

Top module: `pcm_port`

## Requirements
- R1: While reset is low, bclk_o, fsync_o, dout_en_o, dout_o and rx_valid_o are all 0.
- R2: A frame is frame_len_i bit clocks long, with bit clocks numbered 0 to frame_len_i-1. fsync_o is high for the whole of bit clock 0 of every frame and low for all other bit clocks.
- R3: Each bit clock lasts 2*half_div_i system cycles: the high half first, then the low half. The first high half starts half_div_i system cycles after the port is enabled. Output bits change with the high half, and input bits are sampled at the last system edge of the high half.
- R4: When idle_en_i is 1, bclk_o is held at 0 for the bit clocks numbered idle_start_i up to idle_end_i-1, and the bit count keeps running during that window. With a 100-clock frame and a window from 60 to 90, each frame shows 70 clock pulses.
- R5: Transmit channel c drives bits on bit clocks tx_off_i[c] to tx_off_i[c]+tx_len_i[c]-1. The word it sends is sampled from tx_data_i[c] at the start of the frame.
- R6: Bit order is set per channel and per direction. A value of 0 means MSB-first: the first wire bit is word bit len-1. A value of 1 means LSB-first: the first wire bit is word bit 0.
- R7: dout_en_o is 1 only during a transmit slot, and only while force_hiz_i is 0. dout_o is 0 whenever dout_en_o is 0.
- R8: Receive channel c samples din_i on bit clocks rx_off_i[c] to rx_off_i[c]+rx_len_i[c]-1 and places each bit according to R6. Word bits at or above the length read 0. Both words appear on rx_data_o, and rx_valid_o pulses for one system cycle at the start of the frame that follows a completed frame.
- R9: cfg_err_o is 1 in any of these cases: a word length outside 8 to MAX_BITS; LSB-first order with a length above 24; a slot that ends past the frame; half_div_i equal to 0; frame_len_i below 2; or, with idle_en_i set, a window with start not below end, an end past the frame, or any slot that ends after idle_start_i. While cfg_err_o is 1, bclk_o, fsync_o and dout_en_o stay at 0.
- R10: If two transmit slots overlap, the lower-numbered channel drives dout_o.
- R11: The receive and transmit lengths of a channel are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Runs the port; clearing it restarts the frame timing |
| force_hiz_i | input | 1 | Holds data-out in high impedance |
| half_div_i | input | DIV_W | Length of each bit-clock half, in system cycles |
| frame_len_i | input | POS_W | Number of bit clocks per frame |
| idle_en_i | input | 1 | Enables the clock idle window |
| idle_start_i | input | POS_W | First bit clock of the idle window |
| idle_end_i | input | POS_W | First bit clock after the idle window |
| tx_off_i | input | NCH*POS_W | Start bit clock of each transmit slot |
| tx_len_i | input | NCH*LEN_W | Length of each transmit word |
| tx_lsb_i | input | NCH | Transmit order per channel (1 = LSB-first) |
| rx_off_i | input | NCH*POS_W | Start bit clock of each receive slot |
| rx_len_i | input | NCH*LEN_W | Length of each receive word |
| rx_lsb_i | input | NCH | Receive order per channel (1 = LSB-first) |
| tx_data_i | input | NCH*MAX_BITS | Transmit words |
| rx_data_o | output | NCH*MAX_BITS | Last received words |
| rx_valid_o | output | 1 | One-cycle strobe when rx_data_o updates |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out |
| dout_en_o | output | 1 | Data-out drive enable (0 = high impedance) |
| cfg_err_o | output | 1 | Illegal configuration |

## Verification
The hardest case to reach from the ports is where gated clock pulses and slot timing meet. A 100-clock frame with a window from 60 to 90 is run, and its slots are packed right up to the window start. In that setup the bit count must keep advancing while no clock pulses appear. The bench counts the rising edges of bclk_o over three whole frames and compares the total with 210. A cycle-by-cycle model derives the bit-clock phase and position from the number of enabled cycles. Against that model the bench checks every transmitted bit and every received word across mixed bit orders, overlapping slots and settings that must be rejected.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  // True when bit clock pos lies inside a slot that starts at off and is len long.
  function automatic logic slot_hit(input int unsigned pos, input int unsigned off,
                                    input int unsigned len);
    return (pos >= off) && (pos < off + len);
  endfunction

  // Maps the k-th bit on the wire to its index in the parallel word.
  function automatic int unsigned wire_to_word(input int unsigned k, input int unsigned len,
                                               input logic lsb_first);
    return lsb_first ? k : (len - 1 - k);
  endfunction

  // Legality of one slot setting.
  function automatic logic slot_legal(input int unsigned off, input int unsigned len,
                                      input logic lsb_first, input int unsigned frame_len,
                                      input int unsigned max_len, input int unsigned lsb_max,
                                      input logic idle_en, input int unsigned idle_start);
    logic ok;
    ok = (len >= 8) && (len <= max_len);
    if (lsb_first && (len > lsb_max)) ok = 1'b0;
    if (off + len > frame_len) ok = 1'b0;
    if (idle_en && (off + len > idle_start)) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/pcm_timing.sv
module pcm_timing #(
  parameter int POS_W = 10,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  input  logic [POS_W-1:0] frame_len,
  input  logic             idle_en,
  input  logic [POS_W-1:0] idle_start,
  input  logic [POS_W-1:0] idle_end,
  output logic [POS_W-1:0] bitpos_o,
  output logic             live_o,
  output logic             fall_stb_o,
  output logic             wrap_stb_o,
  output logic             in_idle_o,
  output logic             bclk_o,
  output logic             fsync_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             started_q;
  logic [POS_W-1:0] bitpos_q;
  logic             half_done;
  logic             rise_stb;
  logic             last_bit;

  assign half_done  = run && (cnt_q == half_div - 1'b1);
  assign rise_stb   = half_done && !phase_q;
  assign fall_stb_o = half_done && phase_q;
  assign last_bit   = (bitpos_q == frame_len - 1'b1);
  assign wrap_stb_o = rise_stb && (!started_q || last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      phase_q   <= 1'b0;
      started_q <= 1'b0;
      bitpos_q  <= '0;
    end else if (!run) begin
      cnt_q     <= '0;
      phase_q   <= 1'b0;
      started_q <= 1'b0;
      bitpos_q  <= '0;
    end else begin
      if (half_done) begin
        cnt_q   <= '0;
        phase_q <= !phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (rise_stb) begin
        started_q <= 1'b1;
        bitpos_q  <= wrap_stb_o ? '0 : bitpos_q + 1'b1;
      end
    end
  end

  assign live_o    = run && started_q;
  assign bitpos_o  = bitpos_q;
  assign in_idle_o = started_q && idle_en && (bitpos_q >= idle_start) && (bitpos_q < idle_end);
  assign bclk_o    = live_o && phase_q && !in_idle_o;
  assign fsync_o   = live_o && (bitpos_q == '0);

  p_bitpos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (bitpos_q < frame_len));

  p_bclk_rise_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_o) |-> $past(rise_stb));

endmodule

// File: rtl/pcm_cfg_check.sv
module pcm_cfg_check
  import pcm_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int POS_W    = 10,
  parameter int DIV_W    = 8,
  parameter int LEN_W    = 6,
  parameter int MAX_BITS = 32,
  parameter int LSB_MAX  = 24
) (
  input  logic [DIV_W-1:0]            half_div,
  input  logic [POS_W-1:0]            frame_len,
  input  logic                        idle_en,
  input  logic [POS_W-1:0]            idle_start,
  input  logic [POS_W-1:0]            idle_end,
  input  logic [NCH-1:0][POS_W-1:0]   tx_off,
  input  logic [NCH-1:0][LEN_W-1:0]   tx_len,
  input  logic [NCH-1:0]              tx_lsb,
  input  logic [NCH-1:0][POS_W-1:0]   rx_off,
  input  logic [NCH-1:0][LEN_W-1:0]   rx_len,
  input  logic [NCH-1:0]              rx_lsb,
  output logic                        err_o
);
  logic [NCH-1:0] tx_ok;
  logic [NCH-1:0] rx_ok;
  logic           timing_bad;
  logic           window_bad;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    assign tx_ok[c] = slot_legal(32'(tx_off[c]), 32'(tx_len[c]), tx_lsb[c], 32'(frame_len),
                                 MAX_BITS, LSB_MAX, idle_en, 32'(idle_start));
    assign rx_ok[c] = slot_legal(32'(rx_off[c]), 32'(rx_len[c]), rx_lsb[c], 32'(frame_len),
                                 MAX_BITS, LSB_MAX, idle_en, 32'(idle_start));
  end

  assign timing_bad = (half_div == '0) || (frame_len < POS_W'(2));
  assign window_bad = idle_en && ((idle_start >= idle_end) || (idle_end > frame_len));
  assign err_o      = timing_bad || window_bad || !(&tx_ok) || !(&rx_ok);

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_pkg::*;
#(
  parameter int POS_W    = 10,
  parameter int LEN_W    = 6,
  parameter int MAX_BITS = 32,
  localparam int IDX_W   = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                live,
  input  logic                wrap_stb,
  input  logic [POS_W-1:0]    bitpos,
  input  logic [POS_W-1:0]    off,
  input  logic [LEN_W-1:0]    len,
  input  logic                lsb_first,
  input  logic [MAX_BITS-1:0] data_i,
  output logic                active_o,
  output logic                bit_o
);
  logic [MAX_BITS-1:0] word_q;
  logic [IDX_W-1:0]    idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (wrap_stb) word_q <= data_i;
  end

  assign idx      = IDX_W'(wire_to_word(32'(bitpos) - 32'(off), 32'(len), lsb_first));
  assign active_o = live && slot_hit(32'(bitpos), 32'(off), 32'(len));
  assign bit_o    = active_o && word_q[idx];

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_pkg::*;
#(
  parameter int POS_W    = 10,
  parameter int LEN_W    = 6,
  parameter int MAX_BITS = 32,
  localparam int IDX_W   = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                live,
  input  logic                fall_stb,
  input  logic                wrap_stb,
  input  logic [POS_W-1:0]    bitpos,
  input  logic [POS_W-1:0]    off,
  input  logic [LEN_W-1:0]    len,
  input  logic                lsb_first,
  input  logic                din,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o
);
  logic [MAX_BITS-1:0] asm_q;
  logic                seen_q;
  logic                hit;
  logic [IDX_W-1:0]    idx;

  assign hit = live && slot_hit(32'(bitpos), 32'(off), 32'(len));
  assign idx = IDX_W'(wire_to_word(32'(bitpos) - 32'(off), 32'(len), lsb_first));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!run) begin
        asm_q  <= '0;
        seen_q <= 1'b0;
      end else begin
        if (fall_stb && hit) asm_q[idx] <= din;
        if (wrap_stb) begin
          if (seen_q) begin
            data_o  <= asm_q;
            valid_o <= 1'b1;
          end
          seen_q <= 1'b1;
          asm_q  <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_port.sv
module pcm_port #(
  parameter int NCH      = 2,
  parameter int POS_W    = 10,
  parameter int DIV_W    = 8,
  parameter int MAX_BITS = 32,
  parameter int LSB_MAX  = 24,
  localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable_i,
  input  logic                         force_hiz_i,
  input  logic [DIV_W-1:0]             half_div_i,
  input  logic [POS_W-1:0]             frame_len_i,
  input  logic                         idle_en_i,
  input  logic [POS_W-1:0]             idle_start_i,
  input  logic [POS_W-1:0]             idle_end_i,
  input  logic [NCH-1:0][POS_W-1:0]    tx_off_i,
  input  logic [NCH-1:0][LEN_W-1:0]    tx_len_i,
  input  logic [NCH-1:0]               tx_lsb_i,
  input  logic [NCH-1:0][POS_W-1:0]    rx_off_i,
  input  logic [NCH-1:0][LEN_W-1:0]    rx_len_i,
  input  logic [NCH-1:0]               rx_lsb_i,
  input  logic [NCH-1:0][MAX_BITS-1:0] tx_data_i,
  output logic [NCH-1:0][MAX_BITS-1:0] rx_data_o,
  output logic                         rx_valid_o,
  output logic                         bclk_o,
  output logic                         fsync_o,
  input  logic                         din_i,
  output logic                         dout_o,
  output logic                         dout_en_o,
  output logic                         cfg_err_o
);
  logic             run;
  logic [POS_W-1:0] bitpos;
  logic             live;
  logic             fall_stb;
  logic             wrap_stb;
  logic             in_idle;
  logic [NCH-1:0]   tx_act;
  logic [NCH-1:0]   tx_bit;
  logic [NCH-1:0]   rx_val;
  logic             any_slot;
  logic             sel_bit;

  pcm_cfg_check #(
    .NCH(NCH), .POS_W(POS_W), .DIV_W(DIV_W), .LEN_W(LEN_W),
    .MAX_BITS(MAX_BITS), .LSB_MAX(LSB_MAX)
  ) u_cfg (
    .half_div(half_div_i), .frame_len(frame_len_i), .idle_en(idle_en_i),
    .idle_start(idle_start_i), .idle_end(idle_end_i),
    .tx_off(tx_off_i), .tx_len(tx_len_i), .tx_lsb(tx_lsb_i),
    .rx_off(rx_off_i), .rx_len(rx_len_i), .rx_lsb(rx_lsb_i),
    .err_o(cfg_err_o)
  );

  assign run = enable_i && !cfg_err_o;

  pcm_timing #(.POS_W(POS_W), .DIV_W(DIV_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div_i), .frame_len(frame_len_i),
    .idle_en(idle_en_i), .idle_start(idle_start_i), .idle_end(idle_end_i),
    .bitpos_o(bitpos), .live_o(live), .fall_stb_o(fall_stb), .wrap_stb_o(wrap_stb),
    .in_idle_o(in_idle), .bclk_o(bclk_o), .fsync_o(fsync_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pcm_tx_lane #(.POS_W(POS_W), .LEN_W(LEN_W), .MAX_BITS(MAX_BITS)) u_tx (
      .clk(clk), .rst_n(rst_n), .live(live), .wrap_stb(wrap_stb), .bitpos(bitpos),
      .off(tx_off_i[c]), .len(tx_len_i[c]), .lsb_first(tx_lsb_i[c]),
      .data_i(tx_data_i[c]), .active_o(tx_act[c]), .bit_o(tx_bit[c])
    );
    pcm_rx_lane #(.POS_W(POS_W), .LEN_W(LEN_W), .MAX_BITS(MAX_BITS)) u_rx (
      .clk(clk), .rst_n(rst_n), .run(run), .live(live), .fall_stb(fall_stb),
      .wrap_stb(wrap_stb), .bitpos(bitpos), .off(rx_off_i[c]), .len(rx_len_i[c]),
      .lsb_first(rx_lsb_i[c]), .din(din_i), .data_o(rx_data_o[c]), .valid_o(rx_val[c])
    );
  end

  // Lowest-numbered active channel owns the line.
  always_comb begin
    any_slot = 1'b0;
    sel_bit  = 1'b0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (tx_act[c]) begin
        any_slot = 1'b1;
        sel_bit  = tx_bit[c];
      end
    end
  end

  assign dout_en_o  = any_slot && !force_hiz_i;
  assign dout_o     = dout_en_o && sel_bit;
  assign rx_valid_o = &rx_val;

  p_no_data_in_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en_o |-> !in_idle);

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (!bclk_o && !fsync_o && !dout_en_o));

endmodule

// File: tb/pcm_port_tb.sv
`timescale 1ns/1ps
module pcm_port_tb;
  localparam int NCH = 2;
  localparam int POS_W = 10;
  localparam int DIV_W = 8;
  localparam int MB = 32;
  localparam int LW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, fhz = 1'b0, ien = 1'b0, din = 1'b0;
  logic [DIV_W-1:0] hd = '0;
  logic [POS_W-1:0] fl = '0, is_ = '0, ie = '0;
  logic [NCH-1:0][POS_W-1:0] txo = '0, rxo = '0;
  logic [NCH-1:0][LW-1:0] txl = '0, rxl = '0;
  logic [NCH-1:0] txs = '0, rxs = '0;
  logic [NCH-1:0][MB-1:0] txd = '0;
  logic [NCH-1:0][MB-1:0] rxd;
  logic rxv, bclk, fsync, dout, douten, err;

  int vectors = 0, miscompares = 0;
  int n = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcm_port u_dut (
    .clk(clk), .rst_n(rst_n), .enable_i(en), .force_hiz_i(fhz), .half_div_i(hd),
    .frame_len_i(fl), .idle_en_i(ien), .idle_start_i(is_), .idle_end_i(ie),
    .tx_off_i(txo), .tx_len_i(txl), .tx_lsb_i(txs), .rx_off_i(rxo), .rx_len_i(rxl),
    .rx_lsb_i(rxs), .tx_data_i(txd), .rx_data_o(rxd), .rx_valid_o(rxv), .bclk_o(bclk),
    .fsync_o(fsync), .din_i(din), .dout_o(dout), .dout_en_o(douten), .cfg_err_o(err)
  );

  function automatic bit pat(input int p);
    return ((p * 7 + 3) % 11) > 4;
  endfunction

  function automatic bit slot_bad(input int o, input int l, input bit s);
    int e;
    e = o + l;
    if (l < 8 || l > MB) return 1;
    if (s && l > 24) return 1;
    if (e > int'(fl)) return 1;
    if (ien && e > int'(is_)) return 1;
    return 0;
  endfunction

  function automatic bit model_err();
    bit bad;
    bad = (hd == 0) || (fl < 2);
    if (ien && (is_ >= ie || ie > fl)) bad = 1;
    for (int c = 0; c < NCH; c++) begin
      if (slot_bad(int'(txo[c]), int'(txl[c]), txs[c])) bad = 1;
      if (slot_bad(int'(rxo[c]), int'(rxl[c]), rxs[c])) bad = 1;
    end
    return bad;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Enabled-cycle counter: the reference derives all timing from it.
  always @(posedge clk) begin
    if (!rst_n) n <= 0;
    else if (en && !model_err()) n <= n + 1;
    else n <= 0;
  end

  always @(negedge clk) begin
    int h, b, pos, k;
    bit runm, st, ph, idl, hit, ebit, ebclk, efs, een, edo, ev;
    logic [MB-1:0] w;
    h = int'(hd);
    runm = rst_n && en && !model_err();
    st = runm && h > 0 && n >= h;
    b = st ? (n - h) / (2 * h) : 0;
    pos = st ? b % int'(fl) : 0;
    ph = st ? ((n / h) % 2) == 1 : 0;
    idl = ien && pos >= int'(is_) && pos < int'(ie);
    ebclk = st && ph && !idl;
    efs = st && pos == 0;
    hit = 0; ebit = 0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (st && pos >= int'(txo[c]) && pos < int'(txo[c]) + int'(txl[c])) begin
        hit = 1;
        k = pos - int'(txo[c]);
        ebit = txd[c][txs[c] ? k : int'(txl[c]) - 1 - k];
      end
    end
    een = hit && !fhz;
    edo = een && ebit;
    ev = st && ((n - h) % (2 * h)) == 0 && b > 0 && pos == 0;
    vectors++;
    if (!rst_n) begin
      chk("R1 bclk", 32'(bclk), 0);
      chk("R1 fsync", 32'(fsync), 0);
      chk("R1 dout_en", 32'(douten), 0);
      chk("R1 dout", 32'(dout), 0);
      chk("R1 rx_valid", 32'(rxv), 0);
    end else begin
      chk("R9 cfg_err", 32'(err), 32'(model_err()));
      chk("R3/R4 bclk", 32'(bclk), 32'(ebclk));
      chk("R2 fsync", 32'(fsync), 32'(efs));
      chk("R7 dout_en", 32'(douten), 32'(een));
      chk("R5/R6/R10 dout", 32'(dout), 32'(edo));
      chk("R8 rx_valid", 32'(rxv), 32'(ev));
      if (ev) begin
        for (int c = 0; c < NCH; c++) begin
          w = '0;
          for (int j = 0; j < int'(rxl[c]); j++)
            w[rxs[c] ? j : int'(rxl[c]) - 1 - j] = pat(int'(rxo[c]) + j);
          chk("R8/R6/R11 rx_data", rxd[c], w);
        end
      end
    end
    din = pat(pos);
  end

  task automatic wait_cyc(input int c);
    repeat (c) @(negedge clk);
    #1;
  endtask

  task automatic restart();
    en = 0;
    wait_cyc(2);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int rises;
    bit prev;
    wait_cyc(4);
    rst_n = 1;
    wait_cyc(1);

    // Mixed orders, unequal rx/tx lengths (R5, R6, R11)
    hd = 2; fl = 40; ien = 0;
    txo[0] = 1;  txl[0] = 8;  txs[0] = 0;
    txo[1] = 12; txl[1] = 16; txs[1] = 1;
    rxo[0] = 2;  rxl[0] = 10; rxs[0] = 1;
    rxo[1] = 20; rxl[1] = 12; rxs[1] = 0;
    txd[0] = 32'hA5C3_96E1; txd[1] = 32'h1234_F0F0;
    en = 1;
    wait_cyc(660);

    // Forced high impedance (R7)
    restart();
    fhz = 1; en = 1;
    wait_cyc(400);
    restart();
    fhz = 0;

    // Idle window: 100-clock frame, 60..90 (R4)
    hd = 1; fl = 100; ien = 1; is_ = 60; ie = 90;
    txo[0] = 0;  txl[0] = 32; txs[0] = 0;
    txo[1] = 33; txl[1] = 24; txs[1] = 1;
    rxo[0] = 5;  rxl[0] = 20; rxs[0] = 0;
    rxo[1] = 40; rxl[1] = 20; rxs[1] = 1;
    txd[0] = 32'hDEAD_BEEF; txd[1] = 32'h00C0_FFEE;
    en = 1;
    while (fsync !== 1'b1) @(negedge clk);
    rises = (bclk === 1'b1) ? 1 : 0;
    prev = bclk;
    for (int i = 1; i < 600; i++) begin
      @(negedge clk);
      if (bclk === 1'b1 && !prev) rises++;
      prev = bclk;
    end
    vectors++;
    chk("R4 pulses in three frames", 32'(rises), 32'd210);
    wait_cyc(400);

    // Overlapping transmit slots (R10)
    restart();
    hd = 3; fl = 24; ien = 0;
    txo[0] = 4; txl[0] = 8;  txs[0] = 1;
    txo[1] = 8; txl[1] = 12; txs[1] = 0;
    rxo[0] = 0; rxl[0] = 24; rxs[0] = 0;
    rxo[1] = 0; rxl[1] = 8;  rxs[1] = 1;
    txd[0] = 32'h0000_005A; txd[1] = 32'h0000_0C3F;
    en = 1;
    wait_cyc(600);

    // Illegal settings (R9)
    restart();
    txl[0] = 25; txs[0] = 1; en = 1;
    wait_cyc(40);
    vectors++;
    chk("R9 lsb-first over 24", 32'(err), 1);
    restart();
    txl[0] = 8; txs[0] = 1;
    ien = 1; is_ = 10; ie = 20; en = 1;
    wait_cyc(40);
    vectors++;
    chk("R9 slot past idle start", 32'(err), 1);
    restart();
    ien = 0; rxl[1] = 7; en = 1;
    wait_cyc(40);
    vectors++;
    chk("R9 length below 8", 32'(err), 1);
    restart();
    rxl[1] = 8; en = 1;
    wait_cyc(200);
    vectors++;
    chk("R9 legal again", 32'(err), 0);
    finish_run();
  end
endmodule